// File: doc/BRIEF.md
# Cascadable Presettable Up-Counter

This block is a small synchronous up-counter with a parallel preset, an active-low clear and two count enables. Its carry output lets several copies be chained into a counter of any width without a ripple path through the count bits. One parameter picks between a clear that acts at once and a clear that waits for the clock. A second parameter picks a full binary range or a decimal digit range of 0 to 9.

Loading, counting and the clocked clear all act on the rising clock edge. Priority runs in this order: clear, then load, then count, then hold.

To chain stages, connect the same count enable to every stage. Feed the carry of each stage into the carry-gating enable of the next stage. The carry output is decoded without a register from the present count and the carry-gating enable. The next stage therefore sees it before the edge on which the lower stage wraps.

Top module: `presettable_counter`

## Requirements
- R1: With ASYNC_CLR=0, a low `rst_n` at a rising edge sets `count` to 0 after that edge, whatever `load_n`, `cnt_en` and `chain_en` are. Between edges, `count` does not change.
- R2: With ASYNC_CLR=1, `count` reads 0 as soon as `rst_n` goes low, without waiting for a clock edge, and stays 0 while `rst_n` is low.
- R3: With `rst_n` high, a low `load_n` at a rising edge copies `preset_val` into `count`, whatever the enables are.
- R4: With `rst_n` and `load_n` high, `count` advances by one at an edge only when `cnt_en` and `chain_en` are both 1. Otherwise it keeps its value.
- R5: With DECADE=0, the count runs from 0 to 2^WIDTH-1 and wraps to 0 on the next count.
- R6: With DECADE=1, the count wraps from 9 to 0. Any value from 10 up to 2^WIDTH-1, whether reached by load or otherwise, becomes 0 on the next count.
- R7: `carry_out` is 1 exactly when `chain_en` is 1 and `count` equals the top value (2^WIDTH-1 in binary, 9 in decade). `cnt_en` has no effect on it. It follows its inputs in the same cycle.
- R8: Chaining two stages forms a two-digit counter. Both stages share `cnt_en`, and the lower stage's `carry_out` drives the upper stage's `chain_en`. The pair then counts in base 2^WIDTH (or base 10) without skips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on its rising edge |
| rst_n | input | 1 | Active-low clear, immediate or clocked by parameter |
| load_n | input | 1 | Active-low parallel load of `preset_val` |
| cnt_en | input | 1 | Count enable; does not gate the carry |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| preset_val | input | WIDTH | Value loaded when `load_n` is low |
| count | output | WIDTH | Present count |
| carry_out | output | 1 | Top-value flag gated by `chain_en` |

## Verification
The assertions check on every cycle:
- the priority order of clear, load, count and hold;
- the increment;
- the wrap, including recovery from illegal decade values;
- the two-way link between `carry_out` and the top value under `chain_en`;
- in immediate-clear mode, that the count reads zero while the clear is held.

Only the bench scenarios can show the following:
- the count clearing in the middle of a cycle with no edge;
- the clocked-clear copy holding its value until the next edge;
- two chained stages forming a correct 8-bit binary counter and a correct two-digit decimal counter, including the full wrap after 256 counts.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;

  // Highest legal count for a stage
  function automatic int count_max(input int width, input bit decade);
    return decade ? 9 : ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output cnt_op_e op
);

  // Load wins over counting; counting needs both enables
  always_comb begin
    if (!load_n)                op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_STEP;
    else                        op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(count_max(WIDTH, DECADE));

  logic [WIDTH-1:0] stepped;

  generate
    if (DECADE) begin : g_decade
      // Top value and every illegal value fall back to zero
      assign stepped = (cur >= TOP) ? '0 : cur + WIDTH'(1);
    end else begin : g_binary
      assign stepped = cur + WIDTH'(1);
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = preset;
      OP_STEP: nxt = stepped;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             chain_en,
  input  logic [WIDTH-1:0] cur,
  output logic             carry
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(count_max(WIDTH, DECADE));

  assign carry = chain_en & (cur == TOP);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0,
  parameter bit DECADE    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] cur;

  cnt_ctrl ctrl_i (
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  cnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) next_i (
    .op     (op),
    .cur    (cur),
    .preset (preset_val),
    .nxt    (nxt)
  );

  cnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (cur)
  );

  cnt_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) carry_i (
    .chain_en (chain_en),
    .cur      (cur),
    .carry    (carry_out)
  );

  assign count = cur;

endmodule

// File: rtl/counter_props.sv
module counter_props
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0,
  parameter bit DECADE    = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(count_max(WIDTH, DECADE));

  logic started  = 1'b0;
  logic rst_seen = 1'b1;

  always_ff @(posedge clk) begin
    started  <= 1'b1;
    rst_seen <= rst_n;
  end

  // R1: a clear seen at the previous edge leaves zero
  p_clear_r1: assert property (@(posedge clk) disable iff (!started)
    !rst_seen |-> count == '0);

  generate
    if (ASYNC_CLR) begin : g_async_chk
      // R2: while clear is held the count reads zero
      p_async_zero_r2: assert property (@(posedge clk) disable iff (!started)
        !rst_n |-> count == '0);
    end
  endgenerate

  // R3
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset_val));

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_en && chain_en)) |=> count == $past(count));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en && chain_en && count < TOP) |=> count == $past(count) + WIDTH'(1));

  generate
    if (DECADE) begin : g_dec_chk
      // R6: top and illegal values return to zero
      p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && chain_en && count >= TOP) |=> count == '0);
    end else begin : g_bin_chk
      // R5
      p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && chain_en && count == TOP) |=> count == '0);
    end
  endgenerate

  // R7
  p_carry_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (chain_en && count == TOP));

  p_carry_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && count == TOP) |-> carry_out);

endmodule

bind presettable_counter counter_props #(
  .WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR), .DECADE(DECADE)
) props_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_n     (load_n),
  .cnt_en     (cnt_en),
  .chain_en   (chain_en),
  .preset_val (preset_val),
  .count      (count),
  .carry_out  (carry_out)
);

// File: tb/presettable_counter_tb_top.sv
`timescale 1ns/1ps
module presettable_counter_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ld_n  = 1'b1;
  logic       en_a  = 1'b0;
  logic       en_b  = 1'b0;
  logic [3:0] p_lo  = 4'd0;
  logic [3:0] p_hi  = 4'd0;

  logic [3:0] a_lo, a_hi, b_lo, b_hi;
  logic       a_clo, a_chi, b_clo, b_chi;

  int total = 0;
  int bad   = 0;

  // Cascade A: binary, clocked clear
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_a), .chain_en(en_b),
    .preset_val(p_lo), .count(a_lo), .carry_out(a_clo));
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0), .DECADE(1'b0)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_a), .chain_en(a_clo),
    .preset_val(p_hi), .count(a_hi), .carry_out(a_chi));

  // Cascade B: decade, immediate clear
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b1)) dec_lo_i (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_a), .chain_en(en_b),
    .preset_val(p_lo), .count(b_lo), .carry_out(b_clo));
  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1), .DECADE(1'b1)) dec_hi_i (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .cnt_en(en_a), .chain_en(b_clo),
    .preset_val(p_hi), .count(b_hi), .carry_out(b_chi));

  // Reference model built from the requirements
  function automatic logic [3:0] ref_next(input logic [3:0] q, input logic [3:0] p,
                                          input logic ldn, input logic ce,
                                          input logic ch, input logic dec);
    if (!ldn)        return p;
    if (!(ce && ch)) return q;
    if (dec)         return (q >= 4'd9) ? 4'd0 : q + 4'd1;
    return q + 4'd1;
  endfunction

  logic [3:0] ma_lo = 4'd0, ma_hi = 4'd0, mb_lo = 4'd0, mb_hi = 4'd0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ma_lo <= 4'd0;
      ma_hi <= 4'd0;
    end else begin
      ma_lo <= ref_next(ma_lo, p_lo, ld_n, en_a, en_b, 1'b0);
      ma_hi <= ref_next(ma_hi, p_hi, ld_n, en_a, en_b && ma_lo == 4'd15, 1'b0);
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_lo <= 4'd0;
      mb_hi <= 4'd0;
    end else begin
      mb_lo <= ref_next(mb_lo, p_lo, ld_n, en_a, en_b, 1'b1);
      mb_hi <= ref_next(mb_hi, p_hi, ld_n, en_a, en_b && mb_lo == 4'd9, 1'b1);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic eca, ecb;
    eca = en_b && ma_lo == 4'd15;
    ecb = en_b && mb_lo == 4'd9;
    chk("R8 binary cascade value", {a_hi, a_lo}, {ma_hi, ma_lo});
    chk("R8 decade cascade value", {b_hi, b_lo}, {mb_hi, mb_lo});
    chk("R7 binary low carry", a_clo, eca);
    chk("R7 binary high carry", a_chi, eca && ma_hi == 4'd15);
    chk("R7 decade low carry", b_clo, ecb);
    chk("R7 decade high carry", b_chi, ecb && mb_hi == 4'd9);
  endtask

  task automatic drive(input logic r, input logic l, input logic ea, input logic eb,
                       input logic [3:0] pl, input logic [3:0] ph);
    rst_n = r; ld_n = l; en_a = ea; en_b = eb; p_lo = pl; p_hi = ph;
  endtask

  // One cycle: sample at the falling edge, then apply new inputs
  task automatic cycle(input logic r, input logic l, input logic ea, input logic eb,
                       input logic [3:0] pl, input logic [3:0] ph);
    @(negedge clk);
    compare_all();
    drive(r, l, ea, eb, pl, ph);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Reset with load and enables active: clear must win (R1, R2)
    drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 4'd5);
    repeat (3) @(negedge clk);
    chk("R1 clocked clear value", {a_hi, a_lo}, 0);
    chk("R2 immediate clear value", {b_hi, b_lo}, 0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0);

    // Load with enables off (R3)
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 4'd3);
    @(negedge clk);
    chk("R3 load binary", {a_hi, a_lo}, 8'h36);
    chk("R3 load decade", {b_hi, b_lo}, 8'h36);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);

    // Only one enable: hold (R4)
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0);
    @(negedge clk);
    chk("R4 hold with cnt_en low", {a_hi, a_lo}, 8'h36);
    chk("R4 hold decade", {b_hi, b_lo}, 8'h36);

    // Carry ignores cnt_en (R7)
    drive(1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 4'd2);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0);
    #1;
    chk("R7 carry high with cnt_en low", a_clo, 1);
    chk("R7 carry low on illegal decade value", b_clo, 0);
    en_b = 1'b0;
    #1;
    chk("R7 carry drops with chain_en low", a_clo, 0);

    // Decade illegal recovery (R6)
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 4'd12, 4'd15);
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
    @(negedge clk);
    chk("R6 illegal low digit to zero", b_lo, 0);
    chk("R6 upper digit holds without carry", b_hi, 15);
    chk("R4 binary counted once", {a_hi, a_lo}, 8'hfd);
    compare_all();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0);

    // Full 256-count run from zero (R5, R6, R8)
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
    for (int i = 0; i < 255; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
    @(negedge clk);
    chk("R5 binary wraps to zero after 256", {a_hi, a_lo}, 0);
    chk("R6 decade after 256 counts", {b_hi, b_lo}, 8'h56);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);

    // Mid-cycle clear: immediate copy clears, clocked copy waits (R1, R2)
    repeat (3) cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R2 immediate clear between edges", {b_hi, b_lo}, 0);
    chk("R1 clocked copy unchanged between edges", {a_hi, a_lo}, {ma_hi, ma_lo});
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
    chk("R1 clocked copy cleared at edge", {a_hi, a_lo}, 0);

    // Mixed stimulus sweep
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 64) != 0, ($urandom % 8) != 0,
            ($urandom % 4) != 0, ($urandom % 4) != 0,
            4'($urandom), 4'($urandom));
    end
    @(negedge clk);
    compare_all();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule